// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects interrupt lines from system devices and hands each CPU interface the single best interrupt it should take next. Software programs it through a word-wide register port: a global forwarding switch, per-source enables and pending bits, a priority and a sensitivity per source, and a CPU target mask per shared source. Software can also raise software interrupts (IDs 0-15) on any set of CPUs with a single write.

IDs 0-15 are software-raised. IDs 16-31 are private to each CPU and come from a per-CPU input bundle. IDs 32 and up are shared and reach the CPUs named in their target mask. For IDs below 32 the enable and pending state is kept once per CPU. The `bus_cpu` input names the accessing CPU and selects which copy a register access sees. Each CPU output is a valid/ready stream. `irq_valid` stays high while an eligible source exists. `irq_id` names the best eligible source, and a source with a better priority that arrives while `irq_ready` is low replaces it. A cycle with both `irq_valid` and `irq_ready` high takes that ID. This clears its pending bit in the bank of that CPU, and `irq_valid` drops for the following cycle.

Top module: `irq_dist`

## Requirements
- R1: The type register (byte 0x004) reads N in bits [4:0]. The number of sources is (N+1)*32, capped at 510. With the default 64 sources, N reads 1.
- R2: Bit 0 of the control register (byte 0x000) enables forwarding. While it is 0, no `irq_valid` is raised, and pending state is kept.
- R3: Enable-set (0x100) and enable-clear (0x180) are write-1 registers. Source i sits in word i/32 at bit i%32. Bits written as 0 change nothing. Both addresses read back the enable word.
- R4: For IDs 0-31, enable and pending state is held separately per CPU, and `bus_cpu` selects the copy that is read or written. Private inputs for IDs 16-31 only affect their own CPU.
- R5: The target field of source i is in the word at byte 0x800 + ((2*i) & ~3). Even IDs use bits [15:0] and odd IDs use bits [31:16], with CPU k at bit k of the field. For IDs 0-31 the field cannot be written, and it reads back as the accessing CPU's own bit.
- R6: A write to byte 0xF00 sets SGI `wdata[3:0]` pending on every CPU k for which `wdata[8+k]` is set. The target map is bits [23:8].
- R7: Configuration words start at 0xC00, with 16 sources per word and a 2-bit field per source. Field bit 1 set means rising edge and clear means level-high, and field bit 0 reads 0. IDs 0-15 always read as edge (0b10) and ignore writes.
- R8: A level source is pending in every cycle its input is high. Once pending, it stays pending until it is taken, even after the input falls.
- R9: An edge source becomes pending on a rising edge of its input and stays pending until taken. An input that stays high does not make it pending again.
- R10: Among the eligible sources for a CPU, the lowest 4-bit priority value wins, and equal values go to the lowest ID. Priorities are at 0x400 + 4*(i/8), with bits [4*(i%8)+3 : 4*(i%8)].
- R11: `irq_valid` and `irq_id` stay up while `irq_ready` is low. A handshake clears the pending bit of that ID and forces `irq_valid` low on the next cycle.
- R12: Pending-set (0x200) and pending-clear (0x280) are write-1 registers with the same layout as R3. Both addresses read back the pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_cpu | input | CW | Index of the accessing CPU, selects the banked copy |
| bus_rdata | output | 32 | Read data, registered one cycle after the read |
| ppi_in | input | NCPU*16 | Private inputs, CPU k IDs 16-31 at bits [16k+15:16k] |
| spi_in | input | NSRC-32 | Shared inputs, bit j is ID 32+j |
| irq_valid | output | NCPU | An interrupt is offered to CPU k |
| irq_ready | input | NCPU | CPU k takes the offered interrupt |
| irq_id | output | NCPU*IDW | Offered ID for CPU k at bits [IDW*k+IDW-1:IDW*k] |

## Verification
A wrong pending or enable bit shows up on `irq_valid` two cycles after the input event that caused it, because there is one register for the pending state and one for the output. A bad bit in the banked storage makes a CPU that is not targeted take an interrupt, and the bench checks this on all four valid lines together. An arbitration fault shows as a wrong `irq_id` on the cycle after the priorities change. A handshake that fails to clear state keeps `irq_valid` high through the cycle where it must drop, or brings the ID back after it was taken.

// File: rtl/idist_pkg.sv
package idist_pkg;
  localparam int MAX_SRC = 510;
  localparam int LOCAL_N = 32;
  localparam int SGI_N   = 16;

  typedef enum logic [3:0] {
    RG_NONE, RG_CTRL, RG_TYPE, RG_ENS, RG_ENC, RG_PDS, RG_PDC,
    RG_PRIO, RG_TGT, RG_CFG, RG_SGI
  } region_t;

  function automatic region_t reg_decode(input logic [11:0] a);
    region_t r;
    r = RG_NONE;
    if (a[11:2] == 10'h3C0) r = RG_SGI;
    else begin
      case (a[11:10])
        2'b01: r = RG_PRIO;
        2'b10: r = RG_TGT;
        2'b11: r = (a[9:8] == 2'b00) ? RG_CFG : RG_NONE;
        default: begin
          case (a[9:7])
            3'b000: r = (a[6:2] == 5'd0) ? RG_CTRL :
                        (a[6:2] == 5'd1) ? RG_TYPE : RG_NONE;
            3'b010: r = RG_ENS;
            3'b011: r = RG_ENC;
            3'b100: r = RG_PDS;
            3'b101: r = RG_PDC;
            default: r = RG_NONE;
          endcase
        end
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/idist_sense.sv
module idist_sense #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] edge_mode,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl_in;
  end

  assign hit = (edge_mode & lvl_in & ~prev) | (~edge_mode & lvl_in);

  for (genvar j = 0; j < W; j++) begin : g_chk
    // R9: an edge-mode line reports at most one cycle per rising edge
    a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[j] && hit[j]) |=> !(edge_mode[j] && hit[j]));
  end
endmodule

// File: rtl/idist_pick.sv
module idist_pick #(
  parameter int N   = 64,
  parameter int PW  = 4,
  parameter int IDW = 6
) (
  input  logic [N-1:0]    elig,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IDW-1:0]  pick
);
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || prio[i*PW +: PW] < best)) begin
        found = 1'b1;
        best  = prio[i*PW +: PW];
        pick  = IDW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist import idist_pkg::*; #(
  parameter int NCPU = 4,
  parameter int NSRC = 64,
  parameter int PW   = 4,
  localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic [CW-1:0]        bus_cpu,
  output logic [31:0]          bus_rdata,
  input  logic [NCPU*16-1:0]   ppi_in,
  input  logic [NSRC-33:0]     spi_in,
  output logic [NCPU-1:0]      irq_valid,
  input  logic [NCPU-1:0]      irq_ready,
  output logic [NCPU*IDW-1:0]  irq_id
);
  localparam int NSPI    = NSRC - LOCAL_N;
  localparam int SRC_CNT = (NSRC > MAX_SRC) ? MAX_SRC : NSRC;
  localparam int TYPE_N  = NSRC / 32 - 1;
  localparam int NWORD   = NSRC / 32;

  region_t rg;
  logic    wr;

  logic                          ctrl_en;
  logic [NCPU-1:0][31:0]         en_l, pd_l, en_l_n, pd_l_n;
  logic [NSPI-1:0]               en_g, pd_g, en_g_n, pd_g_n;
  logic [NSRC-1:0][PW-1:0]       prio;
  logic [NSPI-1:0][NCPU-1:0]     tgt;
  logic [NSRC-1:16]              cfg_e;
  logic [NSRC-1:0]               edge_all;
  logic [NSRC-1:0]               m_ens, m_enc, m_pds, m_pdc;
  logic [NCPU-1:0][15:0]         sgi_set, ppi_hit;
  logic [NSPI-1:0]               spi_hit;
  logic [NCPU-1:0]               hs, found;
  logic [NCPU-1:0][IDW-1:0]      id_q, pick;
  logic [NCPU-1:0][NSRC-1:0]     elig;
  logic [NSRC-1:0]               en_view, pd_view;
  logic [NSRC-1:0][15:0]         tgt_view;
  logic [31:0]                   rd_val;

  assign rg       = reg_decode(bus_addr);
  assign wr       = bus_sel & bus_wr;
  assign edge_all = {cfg_e, {SGI_N{1'b1}}};
  assign hs       = irq_valid & irq_ready;
  assign irq_id   = id_q;
  assign en_view  = {en_g, en_l[bus_cpu]};
  assign pd_view  = {pd_g, pd_l[bus_cpu]};

  // write-1 masks for the enable and pending banks
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      m_ens[i] = wr && (rg == RG_ENS) && (int'(bus_addr[6:2]) == i / 32) && bus_wdata[i % 32];
      m_enc[i] = wr && (rg == RG_ENC) && (int'(bus_addr[6:2]) == i / 32) && bus_wdata[i % 32];
      m_pds[i] = wr && (rg == RG_PDS) && (int'(bus_addr[6:2]) == i / 32) && bus_wdata[i % 32];
      m_pdc[i] = wr && (rg == RG_PDC) && (int'(bus_addr[6:2]) == i / 32) && bus_wdata[i % 32];
    end
    for (int c = 0; c < NCPU; c++)
      sgi_set[c] = (wr && rg == RG_SGI && bus_wdata[8 + c]) ? (16'd1 << bus_wdata[3:0]) : 16'd0;
  end

  // next state of banked and shared enable / pending
  always_comb begin
    logic        mine;
    logic [31:0] lset, lclr;
    logic [NSPI-1:0] gclr;
    gclr = m_pdc[NSRC-1:32];
    for (int c = 0; c < NCPU; c++) begin
      mine = (int'(bus_cpu) == c);
      lset = {ppi_hit[c], sgi_set[c]} | (mine ? m_pds[31:0] : 32'd0);
      lclr = mine ? m_pdc[31:0] : 32'd0;
      if (hs[c] && id_q[c] < IDW'(32)) lclr = lclr | (32'd1 << id_q[c]);
      if (hs[c] && id_q[c] >= IDW'(32)) gclr = gclr | (NSPI'(1) << (id_q[c] - IDW'(32)));
      pd_l_n[c] = (pd_l[c] & ~lclr) | lset;
      en_l_n[c] = (en_l[c] | (mine ? m_ens[31:0] : 32'd0)) & ~(mine ? m_enc[31:0] : 32'd0);
    end
    pd_g_n = (pd_g & ~gclr) | spi_hit | m_pds[NSRC-1:32];
    en_g_n = (en_g | m_ens[NSRC-1:32]) & ~m_enc[NSRC-1:32];
  end

  // eligibility per CPU and target view for reads
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (i < LOCAL_N) begin : g_loc
      assign tgt_view[i] = 16'(16'd1 << bus_cpu);
      for (genvar c = 0; c < NCPU; c++) begin : g_c
        assign elig[c][i] = ctrl_en & en_l[c][i] & pd_l[c][i];
      end
    end else begin : g_shr
      assign tgt_view[i] = 16'(tgt[i-32]);
      for (genvar c = 0; c < NCPU; c++) begin : g_c
        assign elig[c][i] = ctrl_en & en_g[i-32] & pd_g[i-32] & tgt[i-32][c] & (i < SRC_CNT);
      end
    end
  end

  idist_sense #(.W(NSPI)) u_spi_sense (
    .clk(clk), .rst_n(rst_n), .lvl_in(spi_in),
    .edge_mode(cfg_e[NSRC-1:32]), .hit(spi_hit)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    idist_sense #(.W(16)) u_ppi_sense (
      .clk(clk), .rst_n(rst_n), .lvl_in(ppi_in[c*16 +: 16]),
      .edge_mode(cfg_e[31:16]), .hit(ppi_hit[c])
    );
    idist_pick #(.N(NSRC), .PW(PW), .IDW(IDW)) u_pick (
      .elig(elig[c]), .prio(prio), .found(found[c]), .pick(pick[c])
    );
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      en_l      <= '0;
      pd_l      <= '0;
      en_g      <= '0;
      pd_g      <= '0;
      prio      <= '0;
      tgt       <= '0;
      cfg_e     <= '0;
      id_q      <= '0;
      irq_valid <= '0;
      bus_rdata <= '0;
    end else begin
      en_l <= en_l_n;
      pd_l <= pd_l_n;
      en_g <= en_g_n;
      pd_g <= pd_g_n;
      if (wr && rg == RG_CTRL) ctrl_en <= bus_wdata[0];
      for (int i = 0; i < NSRC; i++)
        if (wr && rg == RG_PRIO && int'(bus_addr[9:2]) == i / 8)
          prio[i] <= bus_wdata[(i % 8) * 4 +: PW];
      for (int k = 0; k < NSPI; k++)
        if (wr && rg == RG_TGT && int'(bus_addr[9:2]) == (k + 32) / 2)
          tgt[k] <= bus_wdata[((k + 32) % 2) * 16 +: NCPU];
      for (int i = 16; i < NSRC; i++)
        if (wr && rg == RG_CFG && int'(bus_addr[7:2]) == i / 16)
          cfg_e[i] <= bus_wdata[(i % 16) * 2 + 1];
      for (int c = 0; c < NCPU; c++) begin
        irq_valid[c] <= hs[c] ? 1'b0 : found[c];
        id_q[c]      <= pick[c];
      end
      if (bus_sel && !bus_wr) bus_rdata <= rd_val;
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (rg)
      RG_CTRL: rd_val[0] = ctrl_en;
      RG_TYPE: rd_val[4:0] = 5'(TYPE_N);
      RG_ENS, RG_ENC:
        for (int w = 0; w < NWORD; w++)
          if (int'(bus_addr[6:2]) == w) rd_val = en_view[w*32 +: 32];
      RG_PDS, RG_PDC:
        for (int w = 0; w < NWORD; w++)
          if (int'(bus_addr[6:2]) == w) rd_val = pd_view[w*32 +: 32];
      RG_PRIO:
        for (int i = 0; i < NSRC; i++)
          if (int'(bus_addr[9:2]) == i / 8) rd_val[(i % 8) * 4 +: PW] = prio[i];
      RG_TGT:
        for (int i = 0; i < NSRC; i++)
          if (int'(bus_addr[9:2]) == i / 2) rd_val[(i % 2) * 16 +: 16] = tgt_view[i];
      RG_CFG:
        for (int i = 0; i < NSRC; i++)
          if (int'(bus_addr[7:2]) == i / 16) rd_val[(i % 16) * 2 + 1] = edge_all[i];
      default: rd_val = '0;
    endcase
  end

  // R2: forwarding off means no request on the following cycle
  a_r2_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> (irq_valid == '0));

  for (genvar c = 0; c < NCPU; c++) begin : g_asrt
    // R11: a taken interrupt leaves a one-cycle gap
    a_r11_gap_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      hs[c] |=> !irq_valid[c]);
    // R6: a targeted SGI write lands in this CPU's pending bank
    a_r6_sgi_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rg == RG_SGI && bus_wdata[8 + c]) |=> pd_l[c][$past(bus_wdata[3:0])]);
    // R4: enable writes by another CPU leave this bank alone
    a_r4_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (rg == RG_ENS || rg == RG_ENC) && int'(bus_cpu) != c) |=> en_l[c] == $past(en_l[c]));
  end

  for (genvar k = 0; k < NSPI; k++) begin : g_alvl
    // R8: a high level input is pending on the next cycle
    a_r8_level_pends: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_in[k] && !cfg_e[32 + k]) |=> pd_g[k]);
  end
endmodule

// File: tb/sim_irq_dist.sv
module sim_irq_dist;
  localparam int NCPU = 4;
  localparam int NSRC = 64;
  localparam int IDW  = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [11:0]       bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic [1:0]        bus_cpu;
  logic [NCPU*16-1:0] ppi_in;
  logic [NSRC-33:0]  spi_in;
  logic [NCPU-1:0]   irq_valid, irq_ready;
  logic [NCPU*IDW-1:0] irq_id;

  irq_dist #(.NCPU(NCPU), .NSRC(NSRC), .PW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .ppi_in(ppi_in), .spi_in(spi_in),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++;
      errors++;
      $display("FAIL all: watchdog, actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] id_of(input int c);
    return 32'(irq_id[c*IDW +: IDW]);
  endfunction

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bw(input logic [11:0] a, input logic [31:0] d, input logic [1:0] cpu);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = cpu;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic br(input logic [11:0] a, input logic [1:0] cpu, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_cpu = cpu;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic take(input int c);
    irq_ready[c] = 1'b1;
    @(negedge clk);
    irq_ready[c] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R2 reset valid", 32'(irq_valid), 32'h0);
    br(12'h000, 2'd0, d); chk("R2 ctrl reset", d, 32'h0);
    br(12'h004, 2'd0, d); chk("R1 type N", d, 32'h1);
  endtask

  task automatic t_local_target();
    logic [31:0] d;
    br(12'h800, 2'd2, d); chk("R5 own mask cpu2", d, 32'h0004_0004);
    bw(12'h83C, 32'hFFFF_FFFF, 2'd0);
    br(12'h83C, 2'd0, d); chk("R5 read-only cpu0", d, 32'h0001_0001);
  endtask

  task automatic t_sgi();
    logic [31:0] d;
    bw(12'h100, 32'h8, 2'd1);
    bw(12'h100, 32'h8, 2'd2);
    bw(12'h000, 32'h1, 2'd0);
    bw(12'hF00, (32'h0006 << 8) | 32'h3, 2'd0);
    wt(1);
    chk("R6 sgi targets", 32'(irq_valid), 32'h6);
    chk("R6 sgi id cpu1", id_of(1), 32'd3);
    chk("R6 sgi id cpu2", id_of(2), 32'd3);
    br(12'h200, 2'd1, d); chk("R4 pend cpu1", d & 32'h8, 32'h8);
    br(12'h200, 2'd0, d); chk("R4 pend cpu0", d & 32'h8, 32'h0);
    take(1);
    chk("R11 gap cpu1", 32'(irq_valid[1]), 32'h0);
    chk("R11 other cpu kept", 32'(irq_valid[2]), 32'h1);
    wt(1);
    chk("R11 taken stays clear", 32'(irq_valid[1]), 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    bw(12'h000, 32'h0, 2'd0);
    wt(1);
    chk("R2 gated", 32'(irq_valid), 32'h0);
    br(12'h200, 2'd2, d); chk("R2 pend kept", d & 32'h8, 32'h8);
    bw(12'h000, 32'h1, 2'd0);
    wt(1);
    chk("R2 reopened", 32'(irq_valid), 32'h4);
    take(2);
    wt(1);
    chk("R11 cpu2 cleared", 32'(irq_valid), 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    bw(12'h180, 32'h0, 2'd1);
    br(12'h100, 2'd1, d); chk("R3 zero write no effect", d, 32'h8);
    bw(12'h180, 32'h8, 2'd1);
    br(12'h180, 2'd1, d); chk("R3 clear bit", d, 32'h0);
    br(12'h100, 2'd2, d); chk("R4 other bank kept", d, 32'h8);
  endtask

  task automatic t_config();
    logic [31:0] d;
    bw(12'hC00, 32'h0, 2'd0);
    br(12'hC00, 2'd0, d); chk("R7 sgi cfg fixed", d, 32'hAAAA_AAAA);
    bw(12'hC08, 32'hFFFF_FFFF, 2'd0);
    br(12'hC08, 2'd0, d); chk("R7 edge bits only", d, 32'hAAAA_AAAA);
    bw(12'hC08, 32'h0, 2'd0);
    br(12'hC08, 2'd0, d); chk("R7 level restore", d, 32'h0);
  endtask

  task automatic t_level();
    bw(12'h850, 32'h0002_0001, 2'd0);
    bw(12'h104, 32'h300, 2'd0);
    spi_in[8] = 1'b1;
    wt(2);
    chk("R8 level valid", 32'(irq_valid), 32'h1);
    chk("R8 level id", id_of(0), 32'd40);
    take(0);
    chk("R11 gap level", 32'(irq_valid[0]), 32'h0);
    wt(1);
    chk("R8 repend while high", 32'(irq_valid[0]), 32'h1);
    spi_in[8] = 1'b0;
    wt(2);
    chk("R8 held after drop", 32'(irq_valid[0]), 32'h1);
    take(0);
    wt(2);
    chk("R8 cleared after take", 32'(irq_valid[0]), 32'h0);
  endtask

  task automatic t_edge();
    bw(12'hC08, 32'h0008_0000, 2'd0);
    spi_in[9] = 1'b1;
    wt(1);
    spi_in[9] = 1'b0;
    wt(1);
    chk("R9 edge latched", 32'(irq_valid), 32'h2);
    chk("R9 edge id", id_of(1), 32'd41);
    spi_in[9] = 1'b1;
    wt(2);
    take(1);
    wt(2);
    chk("R9 no repend while high", 32'(irq_valid[1]), 32'h0);
    spi_in[9] = 1'b0;
    wt(1);
  endtask

  task automatic t_prio();
    logic [31:0] first_id;
    bw(12'h850, 32'h0001_0001, 2'd0);
    bw(12'h414, 32'h0000_0025, 2'd0);
    spi_in[8] = 1'b1;
    spi_in[9] = 1'b1;
    wt(1);
    spi_in[9] = 1'b0;
    wt(2);
    chk("R10 lower value wins", id_of(0), 32'd41);
    bw(12'h414, 32'h0000_0033, 2'd0);
    wt(2);
    chk("R10 tie lowest id", id_of(0), 32'd40);
    first_id = id_of(0);
    wt(3);
    chk("R11 held valid", 32'(irq_valid[0]), 32'h1);
    chk("R11 held id", id_of(0), first_id);
    spi_in[8] = 1'b0;
    wt(1);
    take(0);
    wt(1);
    chk("R10 next source", id_of(0), 32'd41);
    take(0);
    wt(2);
    chk("R10 all taken", 32'(irq_valid[0]), 32'h0);
  endtask

  task automatic t_ppi();
    logic [31:0] d;
    bw(12'h100, 32'h0004_0000, 2'd3);
    ppi_in[3*16 + 2] = 1'b1;
    wt(2);
    chk("R4 private to cpu3", 32'(irq_valid), 32'h8);
    chk("R4 private id", id_of(3), 32'd18);
    br(12'h200, 2'd3, d); chk("R4 pend cpu3", d & 32'h0004_0000, 32'h0004_0000);
    br(12'h200, 2'd0, d); chk("R4 pend cpu0 clear", d & 32'h0004_0000, 32'h0);
    ppi_in[3*16 + 2] = 1'b0;
    wt(1);
    take(3);
    wt(2);
    chk("R8 private cleared", 32'(irq_valid[3]), 32'h0);
  endtask

  task automatic t_pend();
    logic [31:0] d;
    bw(12'h100, 32'h20, 2'd0);
    bw(12'h200, 32'h20, 2'd0);
    wt(1);
    chk("R12 soft set valid", 32'(irq_valid[0]), 32'h1);
    chk("R12 soft set id", id_of(0), 32'd5);
    bw(12'h280, 32'h20, 2'd0);
    wt(1);
    chk("R12 soft clear", 32'(irq_valid[0]), 32'h0);
    br(12'h280, 2'd0, d); chk("R12 pend readback", d & 32'h20, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_cpu = '0; ppi_in = '0; spi_in = '0; irq_ready = '0;
    wt(3);
    rst_n = 1'b1;
    wt(1);
    t_reset();
    t_local_target();
    t_sgi();
    t_ctrl();
    t_enable();
    t_config();
    t_level();
    t_edge();
    t_prio();
    t_ppi();
    t_pend();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule